// File: doc/BRIEF.md
# Fixed-Delay Time-Slot Interchange Switch

This block is a non-blocking time-slot interchange for a star of serial PCM highways. A set of serial input streams, one for the local shelf and the rest for expansion shelves, is turned into 8-bit samples. The samples are stored for one frame in a two-bank speech memory. They are then read back in any order the host chooses and sent out again as serial streams. Each output channel has its own connection entry that names an input channel. Because every entry reads from the bank that was filled during the previous frame, each output frame is an intact copy of one input frame, moved by exactly one frame. This fixed delay keeps traffic isochronous from one shelf to another.

The switch also sources the timing for the remote shelves. It produces a highway bit clock at half the core clock rate and a frame-header pulse one bit period wide. The host writes connection entries through a simple write port. Writes are collected in a pending copy, and the whole copy becomes active at the frame boundary, so no frame is ever switched with a mix of old and new settings. With the default parameters there are nine streams of 128 slots each, which gives 1152 channels and an 11-bit source address.

Top module: `tsw_switch`

## Requirements
- R1: Each highway bit period lasts two `clk` cycles. `hw_clk_o` is low during the first cycle of the period and high during the second. It is low while reset is held, and the first period after reset is released is frame position 0.
- R2: `fh_o` is high for both cycles of the last bit period of each frame (position SLOTS*8-1) and is low in every other period, including during reset.
- R3: Input bits on `rx_i[s]` are captured at the clock edge that ends each bit period. Slot k of stream s uses frame positions 8k to 8k+7, sent MSB first, and is channel number s*SLOTS+k.
- R4: When output channel j (stream o, slot k, j = o*SLOTS+k) has an active entry that is enabled, with a source channel below STREAMS*SLOTS, it carries in frame n+1 the byte that source channel received in frame n.
- R5: `tx_o[o]` uses the same slot and bit positions as the input side, MSB first. Each bit is launched at the edge in the middle of its bit period and is held across the edge that ends the period.
- R6: A connection entry is `cm_wdata[SRC_W]` = enable and `cm_wdata[SRC_W-1:0]` = source channel. An output channel whose active entry has enable 0 sends the idle byte 0xFF (all ones).
- R7: An output channel whose active entry is enabled but whose source channel is STREAMS*SLOTS or higher sends the idle byte 0xFF.
- R8: A `cm_we` write at a clock edge stores `cm_wdata` as the pending entry for output channel `cm_addr`. All pending entries become active together at the edge that ends the frame. A write taken at that same edge is first used in the frame after the next one.
- R9: Reset disables every entry and puts every `tx_o` line at 1. The whole first frame after reset is therefore idle (0xFF) on every output channel.
- R10: Any number of output channels may name the same source channel in one frame, and each of them carries that source's byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, twice the highway bit rate |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_i | input | STREAMS | Serial input highways, one bit per stream |
| tx_o | output | STREAMS | Serial output highways, one bit per stream |
| hw_clk_o | output | 1 | Highway bit clock for the remote shelves |
| fh_o | output | 1 | Frame-header pulse, one bit period wide |
| cm_we | input | 1 | Host connection-entry write strobe |
| cm_addr | input | $clog2(STREAMS*SLOTS) | Output channel whose entry is written |
| cm_wdata | input | SRC_W+1 | Entry: enable in the top bit, source channel below it |

## Verification
A bit driven for frame position p is captured at the edge that ends period p. It reaches the output at the same position one frame later, launched one `clk` cycle after that period begins. The bench therefore sets the inputs on the falling edge that opens each period and reads `tx_o` on the falling edge in the middle of that period. A host write placed before the last period of a frame is expected in the next frame. A write placed in the last period lands on the frame-end edge and is expected one frame later than that, and the bench model moves its pending copy in exactly that order. `hw_clk_o` and `fh_o` are registered counter decodes, so the bench checks them on both falling edges of every period.

// File: rtl/tsw_pkg.sv
package tsw_pkg;

  // Linear channel number of slot 'slot' on stream 'stream'.
  function automatic int unsigned chan_of(input int unsigned stream,
                                          input int unsigned slot,
                                          input int unsigned slots);
    return stream * slots + slot;
  endfunction

  // A connection routes real data only when enabled and in range.
  function automatic logic route_ok(input logic en,
                                    input int unsigned src,
                                    input int unsigned chans);
    return en && (src < chans);
  endfunction

  // Counter wrap test shared by the timing chain.
  function automatic logic at_last(input int unsigned cnt,
                                   input int unsigned limit);
    return cnt == limit - 1;
  endfunction

endpackage

// File: rtl/tsw_timing.sv
module tsw_timing
  import tsw_pkg::*;
#(
  parameter int SLOTS     = 128,
  parameter int SLOT_BITS = 8,
  parameter int SLOT_W    = 7,
  parameter int BIT_W     = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              hw_clk_o,
  output logic              fh_o,
  output logic              sample_o,
  output logic              capture_o,
  output logic              frame_end_o,
  output logic              load_o,
  output logic              shift_o,
  output logic [SLOT_W-1:0] slot_o
);

  logic              phase_q;
  logic [BIT_W-1:0]  bit_q;
  logic [SLOT_W-1:0] slot_q;

  logic last_bit, last_slot;
  assign last_bit  = at_last(int'(bit_q), SLOT_BITS);
  assign last_slot = at_last(int'(slot_q), SLOTS);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= 1'b0;
      bit_q   <= '0;
      slot_q  <= '0;
    end else begin
      phase_q <= ~phase_q;
      if (phase_q) begin
        if (last_bit) begin
          bit_q  <= '0;
          slot_q <= last_slot ? '0 : slot_q + 1'b1;
        end else begin
          bit_q <= bit_q + 1'b1;
        end
      end
    end
  end

  // Second half of a bit period: capture edge. First half: launch edge.
  assign hw_clk_o    = phase_q;
  assign sample_o    = phase_q;
  assign capture_o   = phase_q && last_bit;
  assign frame_end_o = phase_q && last_bit && last_slot;
  assign load_o      = !phase_q && (bit_q == '0);
  assign shift_o     = !phase_q && (bit_q != '0);
  assign fh_o        = last_bit && last_slot;
  assign slot_o      = slot_q;

  AST_HWCLK_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (hw_clk_o != $past(hw_clk_o))); // R1
  AST_FH_OPENS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fh_o) |-> !hw_clk_o); // R2
  AST_FH_TWO_CYCLES: assert property (@(posedge clk) disable iff (!rst_n)
    (fh_o && $past(fh_o)) |=> !fh_o); // R2

endmodule

// File: rtl/tsw_s2p.sv
module tsw_s2p #(
  parameter int STREAMS   = 9,
  parameter int SLOT_BITS = 8
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                sample_i,
  input  logic [STREAMS-1:0]                  rx_i,
  output logic [STREAMS-1:0][SLOT_BITS-1:0]   byte_o
);

  for (genvar s = 0; s < STREAMS; s++) begin : g_lane
    logic [SLOT_BITS-1:0] sh_q;

    always_ff @(posedge clk) begin
      if (!rst_n) sh_q <= '0;
      else if (sample_i) sh_q <= {sh_q[SLOT_BITS-2:0], rx_i[s]};
    end

    // The byte completes with the bit captured at this edge.
    assign byte_o[s] = {sh_q[SLOT_BITS-2:0], rx_i[s]};

    logic unused_top;
    assign unused_top = sh_q[SLOT_BITS-1];
  end

endmodule

// File: rtl/tsw_store.sv
module tsw_store
  import tsw_pkg::*;
#(
  parameter int STREAMS   = 9,
  parameter int SLOTS     = 128,
  parameter int SLOT_BITS = 8,
  parameter int SRC_W     = 11,
  parameter int CH_W      = 11,
  parameter int SLOT_W    = 7
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              capture_i,
  input  logic                              frame_end_i,
  input  logic [SLOT_W-1:0]                 slot_i,
  input  logic [STREAMS-1:0][SLOT_BITS-1:0] wr_byte_i,
  input  logic                              cm_we,
  input  logic [CH_W-1:0]                   cm_addr,
  input  logic [SRC_W:0]                    cm_wdata,
  output logic [STREAMS-1:0][SLOT_BITS-1:0] rd_byte_o
);

  localparam int CHANS = STREAMS * SLOTS;
  localparam logic [SLOT_BITS-1:0] IDLE = {SLOT_BITS{1'b1}};

  // Two frame banks of samples; the bank being written is wr_bank.
  logic [SLOT_BITS-1:0] sm [2][CHANS];
  logic                 wr_bank;

  // Pending and active connection entries.
  logic [CHANS-1:0][SRC_W:0] cm_pend;
  logic [CHANS-1:0][SRC_W:0] cm_act;

  always_ff @(posedge clk) begin
    if (capture_i) begin
      for (int s = 0; s < STREAMS; s++) begin
        sm[wr_bank][CH_W'(chan_of(s, int'(slot_i), SLOTS))] <= wr_byte_i[s];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_bank <= 1'b0;
      cm_pend <= '0;
      cm_act  <= '0;
    end else begin
      if (cm_we && (int'(cm_addr) < CHANS)) cm_pend[cm_addr] <= cm_wdata;
      if (frame_end_i) begin
        wr_bank <= ~wr_bank;
        cm_act  <= cm_pend;
      end
    end
  end

  for (genvar o = 0; o < STREAMS; o++) begin : g_rd
    logic [CH_W-1:0]  idx;
    logic [SRC_W:0]   ent;
    logic             hit;
    assign idx = CH_W'(chan_of(o, int'(slot_i), SLOTS));
    assign ent = cm_act[idx];
    assign hit = route_ok(ent[SRC_W], int'(ent[SRC_W-1:0]), CHANS);
    assign rd_byte_o[o] = hit ? sm[~wr_bank][CH_W'(ent[SRC_W-1:0])] : IDLE;
  end

  AST_BANK_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end_i |=> (wr_bank != $past(wr_bank))); // R4
  AST_CM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_end_i |=> $stable(cm_act)); // R8

endmodule

// File: rtl/tsw_p2s.sv
module tsw_p2s #(
  parameter int STREAMS   = 9,
  parameter int SLOT_BITS = 8
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              load_i,
  input  logic                              shift_i,
  input  logic [STREAMS-1:0][SLOT_BITS-1:0] byte_i,
  output logic [STREAMS-1:0]                tx_o
);

  for (genvar o = 0; o < STREAMS; o++) begin : g_lane
    logic [SLOT_BITS-1:0] sh_q;

    always_ff @(posedge clk) begin
      if (!rst_n)       sh_q <= {SLOT_BITS{1'b1}};
      else if (load_i)  sh_q <= byte_i[o];
      else if (shift_i) sh_q <= {sh_q[SLOT_BITS-2:0], 1'b1};
    end

    assign tx_o[o] = sh_q[SLOT_BITS-1];

    AST_LOAD_MSB: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> (tx_o[o] == $past(byte_i[o][SLOT_BITS-1]))); // R5
  end

endmodule

// File: rtl/tsw_switch.sv
module tsw_switch #(
  parameter int STREAMS   = 9,
  parameter int SLOTS     = 128,
  parameter int SLOT_BITS = 8,
  parameter int SRC_W     = 11,
  localparam int CHANS    = STREAMS * SLOTS,
  localparam int CH_W     = (CHANS > 1) ? $clog2(CHANS) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [STREAMS-1:0] rx_i,
  output logic [STREAMS-1:0] tx_o,
  output logic               hw_clk_o,
  output logic               fh_o,
  input  logic               cm_we,
  input  logic [CH_W-1:0]    cm_addr,
  input  logic [SRC_W:0]     cm_wdata
);

  localparam int SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;
  localparam int BIT_W  = $clog2(SLOT_BITS);

  logic              sample, capture, frame_end, load, shift;
  logic [SLOT_W-1:0] slot;
  logic [STREAMS-1:0][SLOT_BITS-1:0] wr_byte, rd_byte;

  tsw_timing #(
    .SLOTS(SLOTS), .SLOT_BITS(SLOT_BITS), .SLOT_W(SLOT_W), .BIT_W(BIT_W)
  ) u_timing (
    .clk(clk), .rst_n(rst_n), .hw_clk_o(hw_clk_o), .fh_o(fh_o),
    .sample_o(sample), .capture_o(capture), .frame_end_o(frame_end),
    .load_o(load), .shift_o(shift), .slot_o(slot)
  );

  tsw_s2p #(.STREAMS(STREAMS), .SLOT_BITS(SLOT_BITS)) u_s2p (
    .clk(clk), .rst_n(rst_n), .sample_i(sample), .rx_i(rx_i), .byte_o(wr_byte)
  );

  tsw_store #(
    .STREAMS(STREAMS), .SLOTS(SLOTS), .SLOT_BITS(SLOT_BITS),
    .SRC_W(SRC_W), .CH_W(CH_W), .SLOT_W(SLOT_W)
  ) u_store (
    .clk(clk), .rst_n(rst_n), .capture_i(capture), .frame_end_i(frame_end),
    .slot_i(slot), .wr_byte_i(wr_byte), .cm_we(cm_we), .cm_addr(cm_addr),
    .cm_wdata(cm_wdata), .rd_byte_o(rd_byte)
  );

  tsw_p2s #(.STREAMS(STREAMS), .SLOT_BITS(SLOT_BITS)) u_p2s (
    .clk(clk), .rst_n(rst_n), .load_i(load), .shift_i(shift),
    .byte_i(rd_byte), .tx_o(tx_o)
  );

endmodule

// File: tb/tsw_switch_bench.sv
`timescale 1ns/1ps
module tsw_switch_bench;
  localparam int ST  = 3;
  localparam int SL  = 4;
  localparam int SB  = 8;
  localparam int SW  = 11;
  localparam int CH  = ST * SL;
  localparam int CW  = $clog2(CH);
  localparam int FB  = SL * SB;
  localparam int NFR = 9;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [ST-1:0] rx = '0;
  logic [ST-1:0] tx;
  logic          hwclk, fh;
  logic          cm_we = 1'b0;
  logic [CW-1:0] cm_addr = '0;
  logic [SW:0]   cm_wdata = '0;

  int checks = 0;
  int fails  = 0;

  logic [SW:0] m_shadow [CH];
  logic [SW:0] m_next   [CH];
  logic [SW:0] m_act    [CH];

  always #2.5 clk = ~clk;

  tsw_switch #(.STREAMS(ST), .SLOTS(SL), .SLOT_BITS(SB), .SRC_W(SW)) u_tsw_switch (
    .clk(clk), .rst_n(rst_n), .rx_i(rx), .tx_o(tx), .hw_clk_o(hwclk),
    .fh_o(fh), .cm_we(cm_we), .cm_addr(cm_addr), .cm_wdata(cm_wdata)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int got, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s got=%0d exp=%0d", req, what, got, exp);
    end
  endtask

  // Input sample sent on channel ch in frame f.
  function automatic logic [7:0] pat(input int f, input int ch);
    return 8'(f * 73 + ch * 29 + 17);
  endfunction

  // Entry written for output channel ch during frame f; mode cycles with f.
  function automatic logic [SW:0] cfg(input int f, input int ch);
    case (f % 6)
      0: return {1'b1, SW'(ch)};                          // identity
      1: return {1'b1, SW'(CH - 1 - ch)};                 // reversal
      2: return {1'b1, SW'(5)};                           // broadcast, R10
      3: return {(ch % 2 == 0), SW'((ch * 5) % CH)};      // disables, R6
      4: return {1'b1, (ch % 2 == 1) ? SW'(2047) : SW'(CH + ch)}; // R7
      default: return {1'b1, SW'((ch + 7) % CH)};         // rotation
    endcase
  endfunction

  function automatic string tag_of(input int f, input int j);
    if (f == 0) return "R9";
    if (!m_act[j][SW]) return "R6";
    if (int'(m_act[j][SW-1:0]) >= CH) return "R7";
    if (f == 7 && j == 0) return "R8";
    if ((f - 1) % 6 == 2) return "R10";
    return "R3 R4 R5";
  endfunction

  // Called at the falling edge that opens bit period p.
  task automatic run_period(input int p);
    int f = p / FB;
    int q = p % FB;
    if (q == 0 && f > 0) for (int c = 0; c < CH; c++) m_act[c] = m_next[c];
    cm_we = 1'b0;
    for (int s = 0; s < ST; s++) rx[s] = pat(f, s * SL + q / SB)[SB - 1 - q % SB];
    chk(hwclk === 1'b0, "R1", "hw_clk first half", int'(hwclk), 0);
    chk(fh === (q == FB - 1), "R2", "fh first half", int'(fh), int'(q == FB - 1));
    @(negedge clk);
    chk(hwclk === 1'b1, "R1", "hw_clk second half", int'(hwclk), 1);
    chk(fh === (q == FB - 1), "R2", "fh second half", int'(fh), int'(q == FB - 1));
    for (int o = 0; o < ST; o++) begin
      int j = o * SL + q / SB;
      int b = q % SB;
      int e;
      if (f == 0) e = 1;
      else if (m_act[j][SW] && int'(m_act[j][SW-1:0]) < CH)
        e = int'(pat(f - 1, int'(m_act[j][SW-1:0]))[SB - 1 - b]);
      else e = 1;
      chk(tx[o] === 1'(e), tag_of(f, j),
          $sformatf("tx frame %0d chan %0d bit %0d", f, j, b), int'(tx[o]), e);
    end
    // Host writes captured at the edge that ends this period (R8).
    if (q >= 4 && q < 4 + CH) begin
      int c = q - 4;
      if (!(f % 6 == 0 && f > 0 && c == 0)) begin
        cm_we = 1'b1; cm_addr = CW'(c); cm_wdata = cfg(f, c);
        m_shadow[c] = cfg(f, c);
      end
    end
    if (q == FB - 1) begin
      for (int c = 0; c < CH; c++) m_next[c] = m_shadow[c];
      if (f % 6 == 5) begin
        // Lands on the frame-end edge: first used two frames on (R8).
        cm_we = 1'b1; cm_addr = '0; cm_wdata = {1'b1, SW'(9)};
        m_shadow[0] = {1'b1, SW'(9)};
      end
    end
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int c = 0; c < CH; c++) begin
      m_shadow[c] = '0; m_next[c] = '0; m_act[c] = '0;
    end
    repeat (4) @(negedge clk);
    // Reset state: R9, R1, R2
    chk(tx === {ST{1'b1}}, "R9", "tx during reset", int'(tx), (1 << ST) - 1);
    chk(hwclk === 1'b0, "R1", "hw_clk during reset", int'(hwclk), 0);
    chk(fh === 1'b0, "R2", "fh during reset", int'(fh), 0);
    rst_n = 1'b1;
    for (int p = 0; p < NFR * FB; p++) run_period(p);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule